// File: doc/BRIEF.md
# Keyed Configuration Item Read Port

This block gives boot firmware read access to a small fixed store of configuration items. Firmware first writes a 16-bit selector that names one item, then pulls the item's bytes out through a data register. The block keeps the current selection and a 32-bit byte offset into the item. Each read hands back up to `DATA_BYTES` bytes, packed so that the first byte is the most significant, and moves the offset forward.

Accesses arrive on a simple one-cycle request bus. Each request carries a region, a size, a read/write flag and write data. There are three regions. The control region takes selector writes. The data region takes reads of 1 to `DATA_BYTES` bytes. The combined region serves a narrow port, where one address carries both the selector and the data. Every request receives a registered response on the following cycle. The response says whether the access was accepted and carries the read data.

The item store is a parameterised on-chip table. It holds two banks of `ENTRY_LIMIT` entries. Each entry has a length and a present flag. Its contents are fixed when the block is built.

Top module: `cfg_item_port`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `rsp_valid` is 0 and `rsp_rdata` is 0. Reset selects bank 0, entry 0 at offset 0, so the first 4-byte data read after reset returns 0x43464721.
- R2: For every cycle in which `acc_valid` is high, `rsp_valid` is high exactly one cycle later. For every idle cycle, `rsp_valid` is low one cycle later. `rsp_ok` reports whether the access was accepted.
- R3: Selector format: bit 15 picks bank 1 when set, and bits 14:0 give the entry index. Every accepted selector write resets the byte offset to 0, including a write of the current selection.
- R4: An index at or above `ENTRY_LIMIT` (default 20) makes the selection invalid. The selector write is still accepted, and every later read returns zero until the next select. Index `ENTRY_LIMIT-1` is valid.
- R5: A data read of N bytes (N = 1 << `acc_size`) places the byte at the current offset in bits [8N-1:8N-8], the next byte below it, and so on. Bytes past the end of the item read as zero. All bits above 8N are zero.
- R6: A read moves the offset forward by the number of item bytes it returned. A read returns zero, and leaves the offset unchanged, when the offset is at or past the item length or the entry is not present.
- R7: A write to the data region of an accepted size, or a 1-byte write to the combined region, is accepted. It returns zero and changes neither the selection nor the offset.
- R8: Region 0 (control) accepts only 2-byte writes (`acc_size`=1), whose `acc_wdata` is the selector. Reads of it and writes of any other size are rejected.
- R9: On region 2 (combined), a 1-byte access (`acc_size`=0) is a data access, and a 2-byte write is a selector write. Every other size, and a 2-byte read, is rejected. Region 1 (data) accepts sizes up to `DATA_BYTES`. Region 3 rejects everything.
- R10: A rejected access returns `rsp_ok`=0 and `rsp_rdata`=0, and changes no state.
- R11: Bank 0, entry 1 is the identification item. It is 4 bytes long with the first byte equal to 1 | (`DMA_EN` << 1), which is 0x01 by default, and the other bytes 0.
- R12: Store contents:
  - Bank 0, entry 0 is 4 bytes long: 0x43 0x46 0x47 0x21.
  - Every other entry i in bank b is present when i mod 4 is not 3.
  - A present entry has length (3i + 5b) mod (`MAX_LEN`+1), with `MAX_LEN` = 16.
  - Byte k of an entry is (16i + k + 128b) mod 256.
  - An entry that is not present has length 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_region | input | 2 | 0 control, 1 data, 2 combined, 3 unmapped |
| acc_size | input | 2 | Access size as log2 of bytes |
| acc_wdata | input | 16 | Selector value for selector writes |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_ok | output | 1 | Access accepted |
| rsp_rdata | output | DATA_BYTES*8 | Packed read data, zero when not a read |

## Verification
The assertions take for granted that `acc_valid` is low while reset is held. They also assume every input is driven to a known value from the first edge on. The response-timing and zero-data properties rely on this. The stimulus meets both conditions by driving inputs only at falling edges from a single task, with the request held idle through reset. It keeps `acc_size` within the 2-bit range, and it leaves `DATA_BYTES` at its default, so that every data-region size is legal.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

  typedef enum logic [1:0] {
    RG_CTL  = 2'd0,
    RG_DATA = 2'd1,
    RG_COMB = 2'd2,
    RG_NONE = 2'd3
  } region_e;

  typedef enum logic [2:0] {
    K_IDLE   = 3'd0,
    K_REJECT = 3'd1,
    K_SELECT = 3'd2,
    K_READ   = 3'd3,
    K_WNOP   = 3'd4
  } acc_kind_e;

  // Item presence: the two fixed items always exist.
  function automatic bit item_present(int bank, int idx);
    if (bank == 0 && idx < 2) return 1'b1;
    return (idx % 4) != 3;
  endfunction

  function automatic int item_len(int bank, int idx, int max_len);
    if (bank == 0 && idx < 2) return 4;
    if (!item_present(bank, idx)) return 0;
    return (3 * idx + 5 * bank) % (max_len + 1);
  endfunction

  function automatic logic [7:0] item_byte(int bank, int idx, int k, bit dma_en);
    if (bank == 0 && idx == 0) begin
      case (k)
        0: return 8'h43;
        1: return 8'h46;
        2: return 8'h47;
        3: return 8'h21;
        default: return 8'h00;
      endcase
    end
    if (bank == 0 && idx == 1)
      return (k == 0) ? {6'd0, dma_en, 1'b1} : 8'h00;
    return 8'((16 * idx + k + 128 * bank) % 256);
  endfunction

endpackage

// File: rtl/cfg_access_decode.sv
module cfg_access_decode
  import cfg_port_pkg::*;
#(
  parameter int DATA_BYTES = 8,
  localparam int CNT_W = $clog2(DATA_BYTES + 1)
) (
  input  logic             valid,
  input  logic             write,
  input  logic [1:0]       region,
  input  logic [1:0]       size,
  output acc_kind_e        kind,
  output logic [CNT_W-1:0] rd_bytes
);

  int nbytes;

  always_comb begin
    nbytes   = 1 << size;
    kind     = K_REJECT;
    rd_bytes = CNT_W'(1);
    if (!valid) begin
      kind = K_IDLE;
    end else begin
      case (region_e'(region))
        RG_CTL: begin
          if (write && size == 2'd1) kind = K_SELECT;
        end
        RG_DATA: begin
          if (nbytes <= DATA_BYTES) begin
            kind     = write ? K_WNOP : K_READ;
            rd_bytes = CNT_W'(nbytes);
          end
        end
        RG_COMB: begin
          if (size == 2'd0)               kind = write ? K_WNOP : K_READ;
          else if (size == 2'd1 && write) kind = K_SELECT;
        end
        default: kind = K_REJECT;
      endcase
    end
  end

endmodule

// File: rtl/cfg_item_store.sv
module cfg_item_store
  import cfg_port_pkg::*;
#(
  parameter int ENTRY_LIMIT = 20,
  parameter int MAX_LEN     = 16,
  parameter int LANES       = 8,
  parameter bit DMA_EN      = 1'b0,
  localparam int IDX_W  = $clog2(ENTRY_LIMIT),
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int ENTS   = 2 * ENTRY_LIMIT,
  localparam int ENT_W  = $clog2(ENTS),
  localparam int DEPTH  = ENTS * MAX_LEN,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic                  bank,
  input  logic [IDX_W-1:0]      idx,
  input  logic [31:0]           offset,
  output logic [LEN_W-1:0]      len,
  output logic                  present,
  output logic [LANES-1:0][7:0] lanes
);

  logic [7:0]       rom      [DEPTH];
  logic [LEN_W-1:0] len_tab  [ENTS];
  logic             pres_tab [ENTS];

  initial begin
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < ENTRY_LIMIT; i++) begin
        len_tab[b * ENTRY_LIMIT + i]  = LEN_W'(item_len(b, i, MAX_LEN));
        pres_tab[b * ENTRY_LIMIT + i] = item_present(b, i);
        for (int k = 0; k < MAX_LEN; k++)
          rom[(b * ENTRY_LIMIT + i) * MAX_LEN + k] = item_byte(b, i, k, DMA_EN);
      end
    end
  end

  logic             ent_ok;
  logic [ENT_W-1:0] ent;

  assign ent_ok  = 32'(idx) < ENTRY_LIMIT;
  assign ent     = ENT_W'((bank ? ENTRY_LIMIT : 0) + 32'(idx));
  assign len     = ent_ok ? len_tab[ent] : '0;
  assign present = ent_ok ? pres_tab[ent] : 1'b0;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [32:0]       pos;
    logic              in_rng;
    logic [ADDR_W-1:0] addr;
    assign pos    = 33'(offset) + 33'(g);
    assign in_rng = ent_ok && (pos < 33'(MAX_LEN));
    assign addr   = ADDR_W'(32'(ent) * MAX_LEN) + ADDR_W'(pos[LEN_W-1:0]);
    assign lanes[g] = in_rng ? rom[addr] : 8'h00;
  end

endmodule

// File: rtl/cfg_read_packer.sv
module cfg_read_packer #(
  parameter int LANES   = 8,
  parameter int MAX_LEN = 16,
  localparam int LEN_W = $clog2(MAX_LEN + 1),
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic                  sel_ok,
  input  logic                  present,
  input  logic [LEN_W-1:0]      len,
  input  logic [31:0]           offset,
  input  logic [CNT_W-1:0]      nbytes,
  input  logic [LANES-1:0][7:0] lanes,
  output logic [LANES*8-1:0]    value,
  output logic [CNT_W-1:0]      advance
);

  logic take;

  always_comb begin
    value   = '0;
    advance = '0;
    take    = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (CNT_W'(i) < nbytes) begin
        take  = sel_ok && present && ((33'(offset) + 33'(i)) < 33'(len));
        value = (value << 8) | (LANES*8)'(take ? lanes[i] : 8'h00);
        if (take) advance = advance + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/cfg_item_port.sv
module cfg_item_port
  import cfg_port_pkg::*;
#(
  parameter int ENTRY_LIMIT = 20,
  parameter int MAX_LEN     = 16,
  parameter int DATA_BYTES  = 8,
  parameter bit DMA_EN      = 1'b0,
  localparam int IDX_W = $clog2(ENTRY_LIMIT),
  localparam int LEN_W = $clog2(MAX_LEN + 1),
  localparam int CNT_W = $clog2(DATA_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    acc_valid,
  input  logic                    acc_write,
  input  logic [1:0]              acc_region,
  input  logic [1:0]              acc_size,
  input  logic [15:0]             acc_wdata,
  output logic                    rsp_valid,
  output logic                    rsp_ok,
  output logic [DATA_BYTES*8-1:0] rsp_rdata
);

  acc_kind_e                    kind;
  logic [CNT_W-1:0]             rd_bytes;
  logic                         sel_bank;
  logic [IDX_W-1:0]             sel_idx;
  logic                         sel_ok;
  logic [31:0]                  offset;
  logic [LEN_W-1:0]             it_len;
  logic                         it_present;
  logic [DATA_BYTES-1:0][7:0]   it_lanes;
  logic [DATA_BYTES*8-1:0]      pk_value;
  logic [CNT_W-1:0]             pk_adv;

  cfg_access_decode #(.DATA_BYTES(DATA_BYTES)) u_decode (
    .valid    (acc_valid),
    .write    (acc_write),
    .region   (acc_region),
    .size     (acc_size),
    .kind     (kind),
    .rd_bytes (rd_bytes)
  );

  cfg_item_store #(
    .ENTRY_LIMIT (ENTRY_LIMIT),
    .MAX_LEN     (MAX_LEN),
    .LANES       (DATA_BYTES),
    .DMA_EN      (DMA_EN)
  ) u_store (
    .bank    (sel_bank),
    .idx     (sel_idx),
    .offset  (offset),
    .len     (it_len),
    .present (it_present),
    .lanes   (it_lanes)
  );

  cfg_read_packer #(.LANES(DATA_BYTES), .MAX_LEN(MAX_LEN)) u_pack (
    .sel_ok  (sel_ok),
    .present (it_present),
    .len     (it_len),
    .offset  (offset),
    .nbytes  (rd_bytes),
    .lanes   (it_lanes),
    .value   (pk_value),
    .advance (pk_adv)
  );

  logic [14:0] new_idx;
  assign new_idx = acc_wdata[14:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_bank  <= 1'b0;
      sel_idx   <= '0;
      sel_ok    <= 1'b1;
      offset    <= '0;
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= acc_valid;
      rsp_ok    <= 1'b0;
      rsp_rdata <= '0;
      case (kind)
        K_SELECT: begin
          sel_bank <= acc_wdata[15];
          sel_idx  <= IDX_W'(new_idx);
          sel_ok   <= 32'(new_idx) < ENTRY_LIMIT;
          offset   <= '0;
          rsp_ok   <= 1'b1;
        end
        K_READ: begin
          rsp_rdata <= pk_value;
          offset    <= offset + 32'(pk_adv);
          rsp_ok    <= 1'b1;
        end
        K_WNOP:  rsp_ok <= 1'b1;
        default: rsp_ok <= 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/cfg_item_port_chk.sv
module cfg_item_port_chk #(
  parameter int DATA_BYTES = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    acc_valid,
  input logic                    acc_write,
  input logic [1:0]              acc_region,
  input logic [1:0]              acc_size,
  input logic                    rsp_valid,
  input logic                    rsp_ok,
  input logic [DATA_BYTES*8-1:0] rsp_rdata
);

  // R2
  rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> rsp_valid);

  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !rsp_valid);

  // R10
  reject_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ok) |-> (rsp_rdata == '0));

  // R7
  write_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_write) |=> (rsp_rdata == '0));

  // R8
  ctl_read_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write && acc_region == 2'd0) |=> !rsp_ok);

  // R9
  comb_wide_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_region == 2'd2 && acc_size >= 2'd2) |=> !rsp_ok);

  // R9
  comb_narrow_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write && acc_region == 2'd2) |=> (rsp_rdata[DATA_BYTES*8-1:8] == '0));

endmodule

bind cfg_item_port cfg_item_port_chk #(.DATA_BYTES(DATA_BYTES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .acc_valid  (acc_valid),
  .acc_write  (acc_write),
  .acc_region (acc_region),
  .acc_size   (acc_size),
  .rsp_valid  (rsp_valid),
  .rsp_ok     (rsp_ok),
  .rsp_rdata  (rsp_rdata)
);

// File: tb/cfg_item_port_bench.sv
`timescale 1ns/1ps
module cfg_item_port_bench;

  localparam int LIMIT = 20;
  localparam int MAXL  = 16;
  localparam int DB    = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          acc_valid = 1'b0;
  logic          acc_write = 1'b0;
  logic [1:0]    acc_region = 2'd0;
  logic [1:0]    acc_size = 2'd0;
  logic [15:0]   acc_wdata = 16'd0;
  logic          rsp_valid;
  logic          rsp_ok;
  logic [DB*8-1:0] rsp_rdata;

  always #2 clk = ~clk;

  cfg_item_port u_cfg_item_port (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_region(acc_region), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_rdata(rsp_rdata)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic            ok;
    logic [DB*8-1:0] data;
    string           tag;
  } exp_t;
  exp_t sb[$];

  // bench model of the selection
  int  m_bank = 0, m_idx = 0, m_off = 0;
  bit  m_ok = 1;

  function automatic int e_len(int b, int i);
    if (b == 0 && i < 2) return 4;
    if (i % 4 == 3) return 0;
    return (3 * i + 5 * b) % (MAXL + 1);
  endfunction

  function automatic logic [7:0] e_byte(int b, int i, int k);
    logic [31:0] sig;
    sig = 32'h43464721;
    if (b == 0 && i == 0) return sig[31 - 8*k -: 8];
    if (b == 0 && i == 1) return (k == 0) ? 8'h01 : 8'h00;
    return 8'((16 * i + k + 128 * b) % 256);
  endfunction

  function automatic logic [DB*8-1:0] model_read(int n);
    logic [DB*8-1:0] v;
    logic [7:0] by;
    v = '0;
    for (int j = 0; j < n; j++) begin
      by = 8'h00;
      if (m_ok && m_off < e_len(m_bank, m_idx)) begin
        by = e_byte(m_bank, m_idx, m_off);
        m_off++;
      end
      v = (v << 8) | (DB*8)'(by);
    end
    return v;
  endfunction

  task automatic issue(input logic [1:0] rg, input logic wr, input logic [1:0] sz,
                       input logic [15:0] wd, input logic ok,
                       input logic [DB*8-1:0] data, input string tag);
    exp_t e;
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_region = rg; acc_size = sz; acc_wdata = wd;
    e.ok = ok; e.data = data; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic do_select(input logic [1:0] rg, input logic [15:0] sel, input string tag);
    m_bank = sel[15]; m_idx = int'(sel[14:0]); m_off = 0;
    m_ok = (m_idx < LIMIT);
    issue(rg, 1'b1, 2'd1, sel, 1'b1, '0, tag);
  endtask

  task automatic do_read(input logic [1:0] rg, input logic [1:0] sz, input string tag);
    logic [DB*8-1:0] v;
    v = model_read(1 << sz);
    issue(rg, 1'b0, sz, 16'h0, 1'b1, v, tag);
  endtask

  task automatic do_reject(input logic [1:0] rg, input logic wr, input logic [1:0] sz,
                           input logic [15:0] wd, input string tag);
    issue(rg, wr, sz, wd, 1'b0, '0, tag);
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && !done && rsp_valid) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: response with nothing expected, actual ok=%0b expected none", rsp_ok);
      end else begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (rsp_ok !== e.ok || rsp_rdata !== e.data) begin
          errors++;
          $display("FAIL %s: actual ok=%0b data=%h expected ok=%0b data=%h",
                   e.tag, rsp_ok, rsp_rdata, e.ok, e.data);
        end
      end
    end
  end

  initial begin : watchdog
    #400000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset holds response low
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_rdata !== '0) begin
      errors++;
      $display("FAIL R1: actual valid=%0b data=%h expected 0 0", rsp_valid, rsp_rdata);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: actual valid=%0b expected 0 after reset", rsp_valid);
    end

    do_read(2'd1, 2'd2, "R1 signature after reset");
    do_select(2'd0, 16'h0001, "R11 select ident");
    do_read(2'd1, 2'd2, "R11 ident value");
    do_read(2'd1, 2'd2, "R6 read past end");
    do_select(2'd0, 16'h0002, "R3 select entry 2");
    do_read(2'd1, 2'd3, "R5 8-byte read with padding");
    do_select(2'd0, 16'h0002, "R3 reselect rewinds");
    do_read(2'd1, 2'd1, "R5 2-byte read");
    do_read(2'd1, 2'd0, "R6 offset advanced");
    issue(2'd1, 1'b1, 2'd2, 16'hFFFF, 1'b1, '0, "R7 data write accepted");
    do_read(2'd1, 2'd0, "R7 offset untouched by write");
    idle();
    do_select(2'd2, 16'h0002, "R9 combined select");
    do_read(2'd2, 2'd0, "R9 combined 1-byte read");
    do_reject(2'd2, 1'b0, 2'd2, 16'h0, "R9 combined 4-byte rejected");
    do_read(2'd2, 2'd0, "R10 state kept after reject");
    issue(2'd2, 1'b1, 2'd0, 16'h00AA, 1'b1, '0, "R7 combined byte write");
    do_read(2'd2, 2'd0, "R7 combined write no effect");
    do_reject(2'd2, 1'b0, 2'd1, 16'h0, "R9 combined 2-byte read rejected");
    do_reject(2'd0, 1'b0, 2'd1, 16'h0, "R8 control read rejected");
    do_reject(2'd0, 1'b1, 2'd2, 16'h0005, "R8 control 4-byte write rejected");
    do_read(2'd1, 2'd0, "R10 select unchanged after reject");
    do_reject(2'd3, 1'b1, 2'd1, 16'h0005, "R9 unmapped region rejected");
    do_read(2'd1, 2'd0, "R10 unmapped left state");
    idle();
    do_select(2'd0, 16'd20, "R4 select at limit");
    do_read(2'd1, 2'd3, "R4 invalid reads zero");
    do_select(2'd0, 16'h7FFF, "R4 select max index");
    do_read(2'd1, 2'd2, "R4 max index reads zero");
    do_select(2'd0, 16'd19, "R4 last valid index");
    do_read(2'd1, 2'd0, "R4 last valid entry byte");
    do_select(2'd0, 16'h8002, "R3 bank 1 entry 2");
    do_read(2'd1, 2'd2, "R12 bank 1 bytes");
    do_select(2'd0, 16'h0003, "R12 absent entry");
    do_read(2'd1, 2'd2, "R6 absent entry zero");
    do_select(2'd0, 16'h8004, "R12 zero-length entry");
    do_read(2'd1, 2'd0, "R6 zero-length reads zero");
    do_select(2'd0, 16'h8005, "R12 bank 1 entry 5");
    do_read(2'd1, 2'd1, "R5 first half");
    do_read(2'd1, 2'd1, "R5 tail padded");
    do_read(2'd1, 2'd1, "R6 exhausted");
    idle();
    repeat (4) @(negedge clk);

    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R2: actual %0d responses missing expected 0", sb.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule